// File: doc/BRIEF.md
# Power Domain Gating Sequencer

This block drives one switchable power domain through four control lines: a power-switch open line, a reset line, an isolation clamp and a clock gate. Software programs it over a simple valid/write/address/data port. A register write takes effect only when the upper half of the data word holds a 16-bit key. For each control line, software can choose one of two sources: a forced value that it writes itself, or the output of a built-in gating state machine.

In automatic mode the state machine powers the domain down when it receives a start command. The order is clock gate, then isolation, then reset, then switch, with a fixed gap between steps. A wake input brings the domain back up in the reverse order. After the switch closes, there is a long programmable settle interval before reset is released. A deep-sleep force-on bit keeps the domain powered while it is set. A status register reports the state of the sequencer.

Top module: `pwr_gate_seq`

## Requirements
- R1: A write changes a register only when bus_wdata[31:16] equals 16'hCAFE. A write without the key leaves all register contents and all outputs unchanged.
- R2: The control register (address 0) holds the force-enable bits in [3:0] and the forced values in [7:4]. Bit index 0 is clock stop, 1 is isolation, 2 is reset and 3 is switch open. A line whose force bit is set follows its forced value. A line whose force bit is clear follows the state machine.
- R3: Each control output is active high. A value of 1 means switch open (domain unpowered), reset asserted, isolation clamping or clock stopped.
- R4: A power-down asserts clock stop first, one cycle after the start write is captured. Isolation, reset and switch open follow in that order, with GAP_CYC+1 cycles between successive steps.
- R5: A power-up first closes the switch while the other three lines stay asserted. Reset is released SETTLE_CYC+1 cycles later. Isolation is released GAP_CYC+1 cycles after reset, and clock stop is released GAP_CYC+1 cycles after isolation.
- R6: A start command is bit 0 of a keyed write to address 2. It acts only when the mode register (address 1) has bit 0 (auto) and bit 1 (hardware enable) both set and all four force bits are clear.
- R7: While mode bit 2 (force-on) is set, a start command does not power the domain down.
- R8: A start command that arrives while a sequence is running, or while the domain is off, is ignored.
- R9: After reset the domain is off, with all four outputs at 1. All force bits and mode bits are clear.
- R10: Bits [1:0] of the status register (address 3) read 0 for on, 1 for powering down, 2 for off and 3 for powering up.
- R11: wake_req starts a power-up only when the domain is off and automatic mode (R6) is active. In every other case it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 for write |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data, key in [31:16] |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| wake_req | input | 1 | Wake request |
| sw_open | output | 1 | Power switch open (domain unpowered) |
| rst_assert | output | 1 | Domain reset asserted |
| iso_en | output | 1 | Output isolation clamping |
| clk_stop | output | 1 | Domain clock gated |
| dom_state | output | 2 | Sequencer state, same code as status |

## Verification
The hardest conditions to reach are the commands that arrive at the wrong moment. One is a start written in the cycle after a power-down begins. Another is a start while force-on holds the domain up. A third is a start while a single force bit is set whose forced value matches the machine output, so that the outputs alone cannot reveal the override. The bench reaches each condition by issuing keyed writes back to back. It times every output transition against the gap and settle counts, and it treats any transition it did not expect as an error.

// File: rtl/pwr_gate_seq.sv
module pwr_gate_seq #(
  parameter logic [15:0] KEY = 16'hCAFE,
  parameter int SETTLE_CYC = 250000,
  parameter int GAP_CYC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  input  logic        bus_write,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        wake_req,
  output logic        sw_open,
  output logic        rst_assert,
  output logic        iso_en,
  output logic        clk_stop,
  output logic [1:0]  dom_state
);
  localparam int CW = $clog2(SETTLE_CYC + GAP_CYC + 2);

  typedef enum logic [1:0] {ST_ON = 2'd0, ST_DOWN = 2'd1, ST_OFF = 2'd2, ST_UP = 2'd3} st_t;

  st_t          state;
  logic [3:0]   ovr, val, hw, drv;
  logic         auto_en, hw_en, force_on;
  logic [1:0]   step;
  logic [CW-1:0] cnt;

  wire wr      = bus_valid & bus_write & (bus_wdata[31:16] == KEY);
  wire auto_on = auto_en & hw_en & (ovr == 4'd0);
  wire start   = wr & (bus_addr == 2'd2) & bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr <= '0; val <= '0;
      auto_en <= 1'b0; hw_en <= 1'b0; force_on <= 1'b0;
      state <= ST_OFF; hw <= 4'hF; step <= '0; cnt <= '0;
    end else begin
      if (wr && bus_addr == 2'd0) {val, ovr} <= bus_wdata[7:0];
      if (wr && bus_addr == 2'd1) {force_on, hw_en, auto_en} <= bus_wdata[2:0];
      case (state)
        ST_ON: if (start && auto_on && !force_on) begin
          state <= ST_DOWN; step <= '0; cnt <= '0;
        end
        ST_OFF: if (wake_req && auto_on) begin
          state <= ST_UP; step <= '0; cnt <= '0;
        end
        ST_DOWN:
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            hw[step] <= 1'b1;
            if (step == 2'd3) state <= ST_OFF;
            else begin step <= step + 1'b1; cnt <= CW'(GAP_CYC); end
          end
        ST_UP:
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            hw[2'd3 - step] <= 1'b0;
            if (step == 2'd3) state <= ST_ON;
            else begin
              step <= step + 1'b1;
              cnt  <= (step == 2'd0) ? CW'(SETTLE_CYC) : CW'(GAP_CYC);
            end
          end
        default: state <= ST_OFF;
      endcase
    end
  end

  assign drv = (ovr & val) | (~ovr & hw);
  assign clk_stop   = drv[0];
  assign iso_en     = drv[1];
  assign rst_assert = drv[2];
  assign sw_open    = drv[3];
  assign dom_state  = state;

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = {24'h0, val, ovr};
      2'd1:    bus_rdata = {29'h0, force_on, hw_en, auto_en};
      2'd3:    bus_rdata = {30'h0, state};
      default: bus_rdata = 32'h0;
    endcase
  end
endmodule

// File: rtl/pwr_gate_seq_chk.sv
module pwr_gate_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] ovr,
  input logic       sw_open,
  input logic       rst_assert,
  input logic       iso_en,
  input logic       clk_stop,
  input logic [1:0] dom_state
);
  // R4
  down_sw_after_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr == 4'd0 && $past(ovr) == 4'd0 && $rose(sw_open)) |-> $past(rst_assert));
  // R4
  down_iso_after_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr == 4'd0 && $past(ovr) == 4'd0 && $rose(iso_en)) |-> $past(clk_stop));
  // R5
  up_rst_after_sw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr == 4'd0 && $past(ovr) == 4'd0 && $fell(rst_assert)) |-> !$past(sw_open));
  // R5
  up_clk_after_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr == 4'd0 && $past(ovr) == 4'd0 && $fell(clk_stop)) |-> !$past(iso_en));
  // R10
  on_all_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr == 4'd0 && dom_state == 2'd0) |-> !(sw_open | rst_assert | iso_en | clk_stop));
  // R10
  off_all_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr == 4'd0 && dom_state == 2'd2) |-> (sw_open & rst_assert & iso_en & clk_stop));
  // R4
  one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr == 4'd0 && $past(ovr) == 4'd0) |->
      $countones({sw_open, rst_assert, iso_en, clk_stop} ^
                 $past({sw_open, rst_assert, iso_en, clk_stop})) <= 1);
endmodule

bind pwr_gate_seq pwr_gate_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ovr(ovr), .sw_open(sw_open), .rst_assert(rst_assert),
  .iso_en(iso_en), .clk_stop(clk_stop), .dom_state(dom_state)
);

// File: tb/pwr_gate_seq_test.sv
module pwr_gate_seq_test;
  localparam int S = 20;
  localparam int G = 2;

  logic clk = 0, rst_n = 0;
  logic bus_valid = 0, bus_write = 0, wake_req = 0;
  logic [1:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic sw_open, rst_assert, iso_en, clk_stop;
  logic [1:0] dom_state;

  pwr_gate_seq #(.SETTLE_CYC(S), .GAP_CYC(G)) uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wake_req(wake_req), .sw_open(sw_open), .rst_assert(rst_assert),
    .iso_en(iso_en), .clk_stop(clk_stop), .dom_state(dom_state));

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  typedef struct { logic [3:0] v; int d; string tag; } item_t;
  item_t q[$];
  logic [3:0] prev = 4'hF;
  int since = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic expect_chg(input logic [3:0] v, input int d, input string tag);
    item_t it; it.v = v; it.d = d; it.tag = tag; q.push_back(it);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) if (rst_n) begin
    logic [3:0] cur;
    cur = {sw_open, rst_assert, iso_en, clk_stop};
    since++;
    if (cur !== prev) begin
      if (q.size() == 0) check(0, "unexpected change R1/R6/R7/R8/R11", cur, prev);
      else begin
        item_t it;
        it = q.pop_front();
        check(cur === it.v, it.tag, cur, it.v);
        if (it.d != 0) check(since == it.d, {it.tag, " timing"}, since, it.d);
      end
      since = 0;
    end
    prev = cur;
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic wake();
    @(negedge clk); wake_req = 1; @(negedge clk); wake_req = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [31:0] r;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9 reset state
    check({sw_open, rst_assert, iso_en, clk_stop} == 4'hF, "R9 outputs", {sw_open, rst_assert, iso_en, clk_stop}, 4'hF);
    rd(2'd0, r); check(r == 0, "R9 ctrl", r, 0);
    rd(2'd1, r); check(r == 0, "R9 mode", r, 0);
    rd(2'd3, r); check(r == 2, "R10 status off", r, 2);
    // R1 unkeyed write ignored
    wr(2'd0, 32'h1234_00FF); idle(2);
    rd(2'd0, r); check(r == 0, "R1 ctrl unkeyed", r, 0);
    // R2 R3 forced values
    expect_chg(4'h0, 0, "R2 force all low");
    wr(2'd0, 32'hCAFE_000F); idle(2);
    expect_chg(4'h8, 0, "R3 switch bit");
    wr(2'd0, 32'hCAFE_008F); idle(2);
    expect_chg(4'h2, 0, "R3 isolation bit");
    wr(2'd0, 32'hCAFE_002F); idle(2);
    rd(2'd0, r); check(r == 32'h2F, "R2 ctrl readback", r, 32'h2F);
    expect_chg(4'hF, 0, "R2 release to machine");
    wr(2'd0, 32'hCAFE_0000); idle(2);
    // R11 wake without auto ignored, R6 start with partial mode ignored
    wake(); idle(3);
    rd(2'd3, r); check(r == 2, "R11 wake ignored", r, 2);
    wr(2'd1, 32'hCAFE_0001); wake(); idle(3);
    rd(2'd3, r); check(r == 2, "R6 auto without hw enable", r, 2);
    // R5 power-up
    wr(2'd1, 32'hCAFE_0003);
    expect_chg(4'h7, 0, "R5 switch closes first");
    expect_chg(4'h3, S + 1, "R5 reset release");
    expect_chg(4'h1, G + 1, "R5 isolation release");
    expect_chg(4'h0, G + 1, "R5 clock restart");
    wake(); idle(1);
    rd(2'd3, r); check(r == 3, "R10 status up", r, 3);
    idle(S + 3 * G + 10);
    rd(2'd3, r); check(r == 0, "R10 status on", r, 0);
    // R7 force-on blocks start
    wr(2'd1, 32'hCAFE_0007); wr(2'd2, 32'hCAFE_0001); idle(20);
    rd(2'd3, r); check(r == 0, "R7 force-on", r, 0);
    // R6 start ignored with a force bit set (value matches machine output)
    wr(2'd1, 32'hCAFE_0003); wr(2'd0, 32'hCAFE_0001); wr(2'd2, 32'hCAFE_0001); idle(20);
    rd(2'd3, r); check(r == 0, "R6 force bit blocks start", r, 0);
    wr(2'd0, 32'hCAFE_0000);
    // R6 unkeyed start ignored
    wr(2'd2, 32'h0000_0001); idle(20);
    rd(2'd3, r); check(r == 0, "R1 unkeyed start", r, 0);
    // R4 power-down, R8 repeated start
    expect_chg(4'h1, 0, "R4 clock stops first");
    expect_chg(4'h3, G + 1, "R4 isolation");
    expect_chg(4'h7, G + 1, "R4 reset");
    expect_chg(4'hF, G + 1, "R4 switch opens");
    wr(2'd2, 32'hCAFE_0001);
    rd(2'd3, r); check(r == 1, "R10 status down", r, 1);
    wr(2'd2, 32'hCAFE_0001);
    idle(4 * G + 10);
    rd(2'd3, r); check(r == 2, "R8 off after single sequence", r, 2);
    wr(2'd2, 32'hCAFE_0001); idle(20);
    rd(2'd3, r); check(r == 2, "R8 start while off", r, 2);
    check(q.size() == 0, "R4 R5 pending transitions", q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule